// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a chain of identical 4-bit synchronous up-counter stages that together form one wide binary counter. Each stage holds its count in a register that changes only on the rising clock edge. On that edge a stage can be cleared to zero, loaded from a parallel data input, or advanced by one. It advances only when two separate count enables are both high: a broadcast enable (`cnt_en_p`) and a chained enable that comes from the stage below.

Every stage drives a carry output. The carry is high when the stage holds its maximum value and its own chained enable is high. The wrapper feeds each stage's carry into the chained enable of the next stage, so no glue logic is needed between stages. The top-level chained enable (`cnt_en_t`) goes to the lowest stage. The carry of the highest stage is brought out so that several such blocks can be chained in turn. Clear and load are broadcast to every stage. The asynchronous active-low reset is released through a two-flop synchronizer.

Top module: `cnt_cascade`

## Requirements
- R1: While reset is active, and after it is released with no other command, `count` is 0 and `carry_out` is 0.
- R2: `clr` high at a rising edge makes `count` all zeros after that edge, whatever `ld`, `cnt_en_p` and `cnt_en_t` are. Raising `clr` between edges does not change `count` before the next edge.
- R3: With `clr` low, `ld` high at a rising edge copies `ld_data` into `count`, whatever the two enables are.
- R4: With `clr` and `ld` low, `count` goes up by one at an edge only when `cnt_en_p` and `cnt_en_t` are both 1. If either enable is 0, `count` holds.
- R5: Counting past the all-ones value gives zero. This holds for each 4-bit stage and for the whole width.
- R6: `carry_out` is 1 exactly when every bit of `count` is 1 and `cnt_en_t` is 1. It is combinational in `cnt_en_t`.
- R7: The stages together behave as one `N_STAGES*4`-bit binary counter. Bits [4k+3:4k] hold stage k, stage 0 is the least significant, and a stage advances only when every stage below it holds 1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous clear of all stages |
| ld | input | 1 | Synchronous parallel load of all stages |
| cnt_en_p | input | 1 | Count enable broadcast to every stage |
| cnt_en_t | input | 1 | Chained count enable into the lowest stage |
| ld_data | input | N_STAGES*STAGE_W | Parallel load value |
| count | output | N_STAGES*STAGE_W | Current count, stage 0 in the low bits |
| carry_out | output | 1 | Carry of the highest stage |

## Verification
The bench builds the block with three 4-bit stages, so the count is 12 bits wide. With this width, carries ripple across two stage boundaries and the full all-ones-to-zero wrap is reached after a short load. A long run with interleaved gaps in both enables checks that an upper stage moves only when all stages below it are full. It also checks that a gap in either enable freezes the whole chain.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  parameter int unsigned STAGE_W_DEF = 4;

  typedef struct packed {
    logic clr;
    logic ld;
    logic en_p;
  } cnt_ctrl_t;
endpackage

// File: rtl/cnt_rst_sync.sv
module cnt_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [DEPTH-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[DEPTH-2:0], 1'b1};
  end

  assign srst_n = sync_q[DEPTH-1];
endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int unsigned W = STAGE_W_DEF
) (
  input  cnt_ctrl_t    ctrl,
  input  logic         t_en,
  input  logic [W-1:0] q,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_nxt,
  output logic         upd
);
  localparam logic [W-1:0] ONE = W'(1);

  logic adv;
  assign adv = ctrl.en_p & t_en;

  always_comb begin
    q_nxt = q;
    if (ctrl.clr)     q_nxt = '0;
    else if (ctrl.ld) q_nxt = d;
    else if (adv)     q_nxt = q + ONE;
  end

  assign upd = ctrl.clr | ctrl.ld | adv;
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int unsigned W = STAGE_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cnt_ctrl_t    ctrl,
  input  logic         t_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         carry
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] FULL = '1;

  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         upd;

  cnt_next #(.W(W)) u_next (
    .ctrl  (ctrl),
    .t_en  (t_en),
    .q     (q_r),
    .d     (d),
    .q_nxt (q_nxt),
    .upd   (upd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (upd) q_r <= q_nxt;
  end

  assign q     = q_r;
  assign carry = (q_r == FULL) & t_en;

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.clr |=> (q_r == '0)); // R2
  AST_LD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.clr && ctrl.ld) |=> (q_r == $past(d))); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.clr && !ctrl.ld && !(ctrl.en_p && t_en)) |=> $stable(q_r)); // R4
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.clr && !ctrl.ld && ctrl.en_p && t_en) |=> (q_r == $past(q_r) + ONE)); // R5
endmodule

// File: rtl/cnt_cascade.sv
module cnt_cascade
  import cnt_pkg::*;
#(
  parameter int unsigned N_STAGES = 3,
  parameter int unsigned STAGE_W  = STAGE_W_DEF,
  localparam int unsigned TOTAL_W = N_STAGES * STAGE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               ld,
  input  logic               cnt_en_p,
  input  logic               cnt_en_t,
  input  logic [TOTAL_W-1:0] ld_data,
  output logic [TOTAL_W-1:0] count,
  output logic               carry_out
);
  logic            srst_n;
  cnt_ctrl_t       ctrl;
  logic [N_STAGES:0] t_chain;

  cnt_rst_sync #(.DEPTH(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign ctrl.clr  = clr;
  assign ctrl.ld   = ld;
  assign ctrl.en_p = cnt_en_p;
  assign t_chain[0] = cnt_en_t;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    cnt_stage #(.W(STAGE_W)) u_stage (
      .clk   (clk),
      .rst_n (srst_n),
      .ctrl  (ctrl),
      .t_en  (t_chain[k]),
      .d     (ld_data[k*STAGE_W +: STAGE_W]),
      .q     (count[k*STAGE_W +: STAGE_W]),
      .carry (t_chain[k+1])
    );

    if (k > 0) begin : g_chk
      AST_UPPER_WAITS: assert property (@(posedge clk) disable iff (!srst_n)
        (!clr && !ld && (count[k*STAGE_W-1:0] != '1))
        |=> $stable(count[k*STAGE_W +: STAGE_W])); // R7
    end
  end

  assign carry_out = t_chain[N_STAGES];

  AST_CARRY_FULL: assert property (@(posedge clk) disable iff (!srst_n)
    carry_out |-> ((&count) && cnt_en_t)); // R6
  AST_FULL_WRAP: assert property (@(posedge clk) disable iff (!srst_n)
    (!clr && !ld && cnt_en_p && cnt_en_t && (&count)) |=> (count == '0)); // R5
endmodule

// File: tb/sim_cnt_cascade.sv
module sim_cnt_cascade;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         clr, ld, en_p, en_t;
  logic [W-1:0] ld_data;
  logic [W-1:0] count;
  logic         carry_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [W-1:0] mdl;

  always #5 clk = ~clk;

  cnt_cascade #(.N_STAGES(3), .STAGE_W(4)) u0 (
    .clk (clk), .rst_n (rst_n), .clr (clr), .ld (ld),
    .cnt_en_p (en_p), .cnt_en_t (en_t), .ld_data (ld_data),
    .count (count), .carry_out (carry_out)
  );

  task automatic check(input int act, input int exp, input string tag, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // one clock: drive at negedge, update model at the edge, sample 3 ns later
  task automatic step(input logic c, input logic l, input logic p, input logic t,
                      input logic [W-1:0] d, input string tag);
    @(negedge clk);
    clr = c; ld = l; en_p = p; en_t = t; ld_data = d;
    @(posedge clk);
    if (c)           mdl = '0;
    else if (l)      mdl = d;
    else if (p && t) mdl = mdl + 1'b1;
    #3;
    check(int'(count), int'(mdl), tag, "count");
    check(int'(carry_out), int'((mdl == '1) && t), tag, "carry_out");
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; clr = 0; ld = 0; en_p = 0; en_t = 0; ld_data = '0; mdl = '0;
    repeat (3) @(posedge clk);
    #3;
    check(int'(count), 0, "R1", "count in reset");
    check(int'(carry_out), 0, "R1", "carry in reset");
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #3;
    check(int'(count), 0, "R1", "count after release");

    // load regardless of enables, and load winning over counting
    step(0, 1, 0, 0, 12'h0FD, "R3");
    step(0, 1, 1, 1, 12'h0FC, "R3");
    // carries ripple across stage boundaries
    for (int i = 0; i < 6; i++) step(0, 0, 1, 1, '0, "R7");
    // one enable alone holds
    step(0, 0, 1, 0, '0, "R4");
    step(0, 0, 0, 1, '0, "R4");
    step(0, 0, 0, 0, '0, "R4");
    step(0, 0, 1, 1, '0, "R4");
    // carry qualified by the chained enable at full count
    step(0, 1, 0, 0, 12'hFFF, "R6");
    step(0, 0, 1, 0, '0, "R6");
    step(0, 0, 0, 1, '0, "R6");
    // full-width wrap
    step(0, 0, 1, 1, '0, "R5");
    step(0, 1, 0, 0, 12'hFF9, "R5");
    for (int i = 0; i < 10; i++) step(0, 0, 1, 1, '0, "R5");
    // clear beats load and enables
    step(1, 1, 1, 1, 12'hABC, "R2");
    step(0, 1, 0, 0, 12'h3A7, "R3");
    // clear raised between edges has no effect until the edge
    @(negedge clk); clr = 1; ld = 0; en_p = 1; en_t = 1;
    #2;
    check(int'(count), int'(mdl), "R2", "count before edge");
    @(posedge clk); mdl = '0;
    #3;
    check(int'(count), 0, "R2", "count after edge");
    // long run with enable gaps
    step(0, 1, 0, 0, 12'h0F0, "R3");
    for (int i = 0; i < 4500; i++)
      step(0, 0, (i % 7) != 3, (i % 11) != 5, '0, "R7");
    finish_run();
  end
endmodule